// File: doc/BRIEF.md
# DAC Serial Link Host Sequencer

This block sits on the host side of a serial link to a dual-channel 12-bit DAC. It takes high-level requests on a valid/ready handshake and turns each one into one or two 16-bit frames on a three-wire link: an active-low chip select, a serial clock and a data line. There are four requests: program the control word (speed, power and reference selection), write channel A, write channel B, and write both channels so that they update together.

The sequencer runs from a fast system clock. Four count inputs set the link timing in system clock cycles: the half period of the serial clock, the setup from chip select to the first falling clock edge, the hold from the last rising clock edge to chip select release, and the gap with chip select high between frames. The speed and power settings from the most recent control request are kept inside the block and placed into every frame it sends. A data write therefore never undoes a control setting.

Top module: `dac_link_sequencer`

## Requirements
- R1: Each frame has 16 bits and is sent most significant bit first. Bit 15 is select-high, bit 14 is speed, bit 13 is power, bit 12 is select-low, and bits 11..0 carry the payload. The receiver samples a bit on each falling serial clock edge.
- R2: Request op codes are 0 = control, 1 = write A, 2 = write B and 3 = write both. A control request sends select 11 with the payload zero except bits 1..0, which carry `req_ref`. Write A sends select 10 with `req_a`. Write B sends select 00 with `req_b`.
- R3: A write-both request sends two frames. The first is select 01 carrying `req_b`. The second is select 10 carrying `req_a`. Chip select stays high between them for exactly the gap count.
- R4: Speed and power change only on a control request. The held values go into the speed and power bits of every later frame.
- R5: Chip select falls while the serial clock is high. The first falling clock edge comes exactly the setup count of cycles later.
- R6: Inside a frame, every low phase and every high phase between bits of the serial clock lasts exactly the half-period count of cycles.
- R7: While chip select stays low, the data line changes only in the cycle where the serial clock rises.
- R8: Each frame has exactly 16 falling clock edges. After the 16th falling edge the clock rises one half period later. Chip select rises the hold count of cycles after that rise, and the clock stays high whenever chip select is high.
- R9: Ready drops in the cycle after a request is accepted and stays low through every frame of the sequence. It returns exactly the gap count of cycles after chip select rises for the last frame.
- R10: A count input of zero acts as a count of one.
- R11: After reset, chip select is high, the serial clock is high, data is 0 and ready is 1. The held speed and power are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_half | input | CNT_W | Serial clock half period, in cycles |
| cfg_setup | input | CNT_W | Chip select fall to first falling clock edge, in cycles |
| cfg_hold | input | CNT_W | Last clock rise to chip select rise, in cycles |
| cfg_gap | input | CNT_W | Chip select high time after a frame, in cycles |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_op | input | 2 | Request kind (see R2) |
| req_speed | input | 1 | Speed setting, used by control requests |
| req_power | input | 1 | Power setting, used by control requests |
| req_ref | input | 2 | Reference selection, used by control requests |
| req_a | input | DATA_W | Channel A value |
| req_b | input | DATA_W | Channel B value |
| link_cs_n | output | 1 | Chip select, active low |
| link_sclk | output | 1 | Serial clock, idle high |
| link_sdo | output | 1 | Serial data |

## Verification
Each request kind is sent with its own payload pattern: all ones, all zeros, alternating bits, and single bits at both ends. A wrong bit order or a slipped payload position therefore shows up as a different word. Control requests are placed between data writes with different speed and power values, so the bench can tell held settings apart from settings taken from the data request. Write-both requests check that two frames appear in the right order with an exact gap. The whole stream runs under three timing configurations, one of them all zeros. This separates an off-by-one count from a correct one and confirms that zero counts are clamped to one.

// File: rtl/dac_link_sequencer.sv
module dac_link_sequencer #(
  parameter int CNT_W  = 8,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cfg_half,
  input  logic [CNT_W-1:0]  cfg_setup,
  input  logic [CNT_W-1:0]  cfg_hold,
  input  logic [CNT_W-1:0]  cfg_gap,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic              req_speed,
  input  logic              req_power,
  input  logic [1:0]        req_ref,
  input  logic [DATA_W-1:0] req_a,
  input  logic [DATA_W-1:0] req_b,
  output logic              link_cs_n,
  output logic              link_sclk,
  output logic              link_sdo
);
  localparam int FRAME_W = DATA_W + 4;
  localparam int BIT_W   = $clog2(FRAME_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);
  localparam logic [1:0] OP_CTRL = 2'd0, OP_A = 2'd1, OP_B = 2'd2, OP_BOTH = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_LOW, S_HIGH, S_HOLD, S_GAP} state_t;

  state_t             state;
  logic [CNT_W-1:0]   cnt, lim;
  logic [FRAME_W-1:0] sr, pend_word, first_word, second_word;
  logic [BIT_W-1:0]   bitn;
  logic               pend, spd_q, pwr_q, cs_n_q, sclk_q;
  logic               nspd, npwr, done, accept;

  assign req_ready = (state == S_IDLE);
  assign accept    = req_valid && req_ready;
  assign link_cs_n = cs_n_q;
  assign link_sclk = sclk_q;
  assign link_sdo  = sr[FRAME_W-1];

  assign nspd = (req_op == OP_CTRL) ? req_speed : spd_q;
  assign npwr = (req_op == OP_CTRL) ? req_power : pwr_q;

  always_comb begin
    case (state)
      S_SETUP:       lim = cfg_setup;
      S_LOW, S_HIGH: lim = cfg_half;
      S_HOLD:        lim = cfg_hold;
      default:       lim = cfg_gap;
    endcase
  end
  assign done = ({1'b0, cnt} + (CNT_W+1)'(1)) >= {1'b0, lim};

  always_comb begin
    case (req_op)
      OP_CTRL: first_word = {1'b1, nspd, npwr, 1'b1, {(DATA_W-2){1'b0}}, req_ref};
      OP_A:    first_word = {1'b1, nspd, npwr, 1'b0, req_a};
      OP_B:    first_word = {1'b0, nspd, npwr, 1'b0, req_b};
      default: first_word = {1'b0, nspd, npwr, 1'b1, req_b};
    endcase
  end
  assign second_word = {1'b1, nspd, npwr, 1'b0, req_a};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      sr        <= '0;
      pend_word <= '0;
      pend      <= 1'b0;
      spd_q     <= 1'b0;
      pwr_q     <= 1'b0;
      cs_n_q    <= 1'b1;
      sclk_q    <= 1'b1;
      bitn      <= '0;
    end else begin
      if (state == S_IDLE || done) cnt <= '0;
      else                         cnt <= cnt + CNT_W'(1);
      case (state)
        S_IDLE: if (accept) begin
          spd_q     <= nspd;
          pwr_q     <= npwr;
          sr        <= first_word;
          pend      <= (req_op == OP_BOTH);
          pend_word <= second_word;
          cs_n_q    <= 1'b0;
          bitn      <= '0;
          state     <= S_SETUP;
        end
        S_SETUP: if (done) begin
          sclk_q <= 1'b0;
          state  <= S_LOW;
        end
        S_LOW: if (done) begin
          sclk_q <= 1'b1;
          sr     <= sr << 1;
          if (bitn == LAST_BIT) state <= S_HOLD;
          else begin
            bitn  <= bitn + BIT_W'(1);
            state <= S_HIGH;
          end
        end
        S_HIGH: if (done) begin
          sclk_q <= 1'b0;
          state  <= S_LOW;
        end
        S_HOLD: if (done) begin
          cs_n_q <= 1'b1;
          state  <= S_GAP;
        end
        default: if (done) begin
          if (pend) begin
            pend   <= 1'b0;
            sr     <= pend_word;
            cs_n_q <= 1'b0;
            bitn   <= '0;
            state  <= S_SETUP;
          end else state <= S_IDLE;
        end
      endcase
    end
  end

  assert_sclk_idle_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    link_cs_n |-> link_sclk);
  assert_frame_starts_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(link_cs_n) |-> link_sclk);
  assert_busy_while_framing_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !link_cs_n |-> !req_ready);
  assert_accept_drops_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  assert_sdo_moves_on_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!link_cs_n && $past(!link_cs_n) && !$rose(link_sclk)) |-> $stable(link_sdo));
endmodule

// File: tb/test_dac_link_sequencer.sv
module test_dac_link_sequencer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] cfg_half = 8'd3, cfg_setup = 8'd2, cfg_hold = 8'd2, cfg_gap = 8'd4;
  logic req_valid = 1'b0, req_speed = 1'b0, req_power = 1'b0;
  logic [1:0] req_op = 2'd0, req_ref = 2'd0;
  logic [11:0] req_a = '0, req_b = '0;
  logic req_ready, link_cs_n, link_sclk, link_sdo;

  dac_link_sequencer i_dac_link_sequencer (.*);

  always #10 clk = ~clk;

  typedef struct { logic [15:0] w; string tag; } exp_t;
  exp_t q[$];
  int checks = 0, fails = 0;
  bit m_spd = 0, m_pwr = 0, zero_mode = 0;

  function automatic int eff(logic [7:0] v); return (v == 0) ? 1 : int'(v); endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(logic [15:0] w, string tag);
    exp_t e; e.w = w; e.tag = tag; q.push_back(e);
  endtask

  task automatic send(logic [1:0] op, bit s, bit p, logic [1:0] r,
                      logic [11:0] a, logic [11:0] b, string tag);
    if (op == 2'd0) begin m_spd = s; m_pwr = p; end
    case (op)
      2'd0: push({1'b1, m_spd, m_pwr, 1'b1, 10'd0, r}, tag);
      2'd1: push({1'b1, m_spd, m_pwr, 1'b0, a}, tag);
      2'd2: push({1'b0, m_spd, m_pwr, 1'b0, b}, tag);
      default: begin
        push({1'b0, m_spd, m_pwr, 1'b1, b}, tag);
        push({1'b1, m_spd, m_pwr, 1'b0, a}, tag);
      end
    endcase
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_op = op; req_speed = s; req_power = p;
    req_ref = r; req_a = a; req_b = b;
    @(negedge clk);
    req_valid = 1'b0; req_speed = ~s; req_power = ~p; req_a = ~a; req_b = ~b;
  endtask

  task automatic drain;
    while (q.size() != 0 || !req_ready) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // monitor
  bit prev_cs = 1, prev_sclk = 1, prev_sdo = 0, prev_ready = 1, gap_active = 0;
  int run = 0, hi_run = 0, nbits = 0;
  logic [15:0] word = '0;
  always @(negedge clk) if (rst_n) begin
    string tt;
    tt = zero_mode ? "R10" : "";
    if (prev_cs && !link_cs_n) begin
      if (gap_active) chk(hi_run == eff(cfg_gap), zero_mode ? "R10" : "R3", hi_run, eff(cfg_gap));
      gap_active = 0;
      chk(!req_ready, "R9", req_ready, 0);
      run = 1; nbits = 0; word = '0;
    end else if (!prev_cs && !link_cs_n) begin
      if (req_ready) chk(0, "R9", req_ready, 0);
      if (link_sclk != prev_sclk) begin
        if (!link_sclk) begin
          if (nbits == 0) chk(run == eff(cfg_setup), zero_mode ? tt : "R5", run, eff(cfg_setup));
          else            chk(run == eff(cfg_half), zero_mode ? tt : "R6", run, eff(cfg_half));
          word = {word[14:0], link_sdo};
          nbits++;
        end else chk(run == eff(cfg_half), zero_mode ? tt : "R6", run, eff(cfg_half));
        run = 1;
      end else run++;
      if (link_sdo != prev_sdo) chk(link_sclk && !prev_sclk, "R7", {prev_sclk, link_sclk}, 2'b01);
    end else if (!prev_cs && link_cs_n) begin
      chk(nbits == 16, "R8", nbits, 16);
      chk(link_sclk && run == eff(cfg_hold), zero_mode ? "R10" : "R8", run, eff(cfg_hold));
      if (q.size() == 0) chk(0, "R1", word, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk(word == e.w, e.tag, word, e.w);
      end
      gap_active = 1; hi_run = 1;
    end else if (gap_active) begin
      if (req_ready && !prev_ready) begin
        chk(hi_run == eff(cfg_gap), zero_mode ? "R10" : "R9", hi_run, eff(cfg_gap));
        gap_active = 0;
      end else hi_run++;
    end
    prev_cs = link_cs_n; prev_sclk = link_sclk; prev_sdo = link_sdo; prev_ready = req_ready;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(link_cs_n && link_sclk && !link_sdo && req_ready, "R11",
        {link_cs_n, link_sclk, link_sdo, req_ready}, 4'b1101);
    send(2'd1, 0, 0, 2'd0, 12'hABC, 12'h000, "R11");
    send(2'd0, 1, 0, 2'd2, 12'h000, 12'h000, "R2");
    send(2'd2, 0, 1, 2'd3, 12'h000, 12'h123, "R4");
    send(2'd1, 0, 0, 2'd0, 12'hFFF, 12'h000, "R1");
    send(2'd3, 0, 0, 2'd0, 12'h5A5, 12'h0F0, "R3");
    send(2'd0, 0, 1, 2'd1, 12'h000, 12'h000, "R2");
    send(2'd2, 1, 0, 2'd0, 12'h000, 12'h000, "R4");
    drain();
    cfg_half = 0; cfg_setup = 0; cfg_hold = 0; cfg_gap = 0; zero_mode = 1;
    send(2'd3, 0, 0, 2'd0, 12'h801, 12'hAAA, "R10");
    send(2'd1, 0, 0, 2'd0, 12'h555, 12'h000, "R10");
    drain();
    cfg_half = 5; cfg_setup = 4; cfg_hold = 3; cfg_gap = 6; zero_mode = 0;
    send(2'd0, 1, 1, 2'd1, 12'h000, 12'h000, "R2");
    send(2'd1, 0, 0, 2'd0, 12'h801, 12'h000, "R1");
    send(2'd3, 0, 0, 2'd0, 12'h001, 12'h800, "R3");
    drain();
    chk(q.size() == 0, "R3", q.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog R9 actual=%0d expected=0", q.size());
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule